// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block takes two-channel PCM audio from a three-wire serial link (bit clock, word clock, data line) and turns it into pairs of signed 24-bit samples. The block runs entirely on the bit clock and assumes the word clock is phase-locked to it. A 3-bit format code picks one of five framings: left-justified to the word-clock transition (MSB first), the I2S framing with its one-bit delay and inverted channel polarity, or right-justified to the end of the half-frame with a sample length of 16, 20 or 24 bits.

Each completed left/right pair is offered on a valid/ready output. Once `smp_valid` is high, `smp_left` and `smp_right` hold steady until a cycle with `smp_ready` high. The link cannot be paused, so if a new pair completes while the previous one is still waiting, the new pair is discarded. A pair completes on the bit-clock edge that samples the word-clock transition ending the right channel. `smp_valid` rises right after that edge.

The format code is registered at each word-clock transition. Its reset value selects the 24-bit MSB-justified framing. If the registered code changes at a transition, any half-captured pair is dropped and the receiver resynchronises over the next two transitions. The first transition seen after reset only marks a boundary, because the half-frame in progress at reset is incomplete.

Top module: `aud_serial_rx`

## Requirements
- R1: Data is sampled on the rising bit-clock edge, MSB first, as two's complement. With format code 2, the 24-bit sample's MSB is the bit sampled on the same edge that first sees the new word-clock level.
- R2: With format code 3 (I2S), the MSB arrives one bit clock after the edge that sees the transition. A low word clock marks the left channel.
- R3: With format code 0, the sample is the last 16 bits before the closing transition. It appears in bits 23:8 of the output, and bits 7:0 are zero.
- R4: With format code 1, the sample is the last 20 bits before the closing transition. It appears in bits 23:4, and bits 3:0 are zero.
- R5: With format code 4, the sample is the last 24 bits before the closing transition.
- R6: With format codes 0, 1, 2 and 4, a high word clock marks the left channel and a low word clock marks the right channel.
- R7: Bit clocks in a half-frame beyond those carrying the sample are ignored, for half-frames from the format's minimum (32 bits for code 0, 40 for code 1, 48 otherwise) up to 2^CNT_W bits.
- R8: Format codes 5, 6 and 7 behave exactly like code 2.
- R9: Exactly one pair is emitted per left-then-right frame. `smp_valid` rises right after the edge that samples the transition closing the right channel. A right half-frame with no captured left half, and the half-frame cut by reset, produce no output.
- R10: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_left` and `smp_right` stay unchanged. A pair that completes during that time is discarded.
- R11: During reset and immediately after it, `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; the block's only clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Format code, registered at word-clock transitions |
| word_clk | input | 1 | Channel-select word clock |
| ser_data | input | 1 | Serial audio data |
| smp_valid | output | 1 | A left/right pair is available |
| smp_ready | input | 1 | Downstream accepts the pair |
| smp_left | output | 24 | Left sample, signed, MSB-aligned |
| smp_right | output | 24 | Right sample, signed, MSB-aligned |

## Verification
A bit counter that slips by one cycle shows up in the very first emitted pair after the fault. Every sample comes out doubled or halved, with a stray bit at one end, so the fault is visible within one frame of bit clocks. A synchroniser or pairing flag in the wrong state makes a pair go missing or appear twice. It can also swap the two channels, which is caught when the next `smp_valid` is compared with the expected pair. A wrong holding stage changes the outputs while they are stalled, and that is visible in the next cycle with `smp_ready` low.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [2:0] {
    FMT_L16 = 3'd0,
    FMT_L20 = 3'd1,
    FMT_MSB = 3'd2,
    FMT_I2S = 3'd3,
    FMT_L24 = 3'd4
  } fmt_code_e;

  // decoded framing of one half-frame
  typedef struct packed {
    logic       rjust;   // sample ends at the closing transition
    logic       delay1;  // MSB one bit clock after the transition, left = low
    logic [4:0] len;     // sample length in bits
  } fmt_t;

  typedef enum logic [1:0] {
    SY_IDLE = 2'd0,  // word-clock level not yet seen
    SY_HUNT = 2'd1,  // waiting for a boundary
    SY_LOCK = 2'd2   // half-frames are complete
  } sync_e;

  function automatic fmt_t fmt_decode(input logic [2:0] code);
    fmt_t f;
    f.rjust  = 1'b0;
    f.delay1 = 1'b0;
    f.len    = 5'd24;
    case (code)
      FMT_L16: begin f.rjust = 1'b1; f.len = 5'd16; end
      FMT_L20: begin f.rjust = 1'b1; f.len = 5'd20; end
      FMT_I2S: f.delay1 = 1'b1;
      FMT_L24: f.rjust = 1'b1;
      default: ;  // 2 and the unused codes: MSB-justified 24-bit
    endcase
    return f;
  endfunction

endpackage

// File: rtl/aud_rx_frame_sync.sv
module aud_rx_frame_sync
  import aud_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_clk,
  input  logic [2:0] fmt_sel,
  output logic       tr,        // transition sampled this edge
  output logic       lat,       // transition closes a complete half-frame
  output logic       chg,       // transition carries a format change
  output logic       lvl_prev,  // level of the half-frame being closed
  output fmt_t       fmt
);

  logic       lr_q;
  sync_e      st;
  logic [2:0] code_q;

  assign tr       = (st != SY_IDLE) && (word_clk != lr_q);
  assign chg      = tr && (fmt_sel != code_q);
  assign lat      = tr && (st == SY_LOCK) && !chg;
  assign lvl_prev = lr_q;
  assign fmt      = fmt_decode(code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      st     <= SY_IDLE;
      code_q <= 3'(FMT_MSB);
    end else begin
      lr_q <= word_clk;
      if (tr) code_q <= fmt_sel;
      case (st)
        SY_IDLE: st <= SY_HUNT;
        SY_HUNT: if (tr && !chg) st <= SY_LOCK;
        SY_LOCK: if (chg) st <= SY_HUNT;
        default: st <= SY_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_data,
  input  logic                tr,
  input  fmt_t                fmt,
  output logic [SAMPLE_W-1:0] word
);

  localparam logic [CNT_W-1:0] SPAN = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [SAMPLE_W-1:0] sr, sr_base, sr_nxt;
  logic [CNT_W-1:0]    cnt, idx, first, last;
  logic                shift_en;
  logic [4:0]          pad;

  // bit index within the half-frame; 0 on the transition edge
  assign idx   = tr ? '0 : cnt;
  assign first = {{(CNT_W-1){1'b0}}, fmt.delay1};
  assign last  = first + SPAN;

  always_comb begin
    shift_en = fmt.rjust || ((idx >= first) && (idx < last));
    sr_base  = (tr && !fmt.rjust) ? '0 : sr;
    sr_nxt   = shift_en ? {sr_base[SAMPLE_W-2:0], ser_data} : sr_base;
  end

  // pre-update contents form the closed half-frame's sample
  assign pad  = 5'(SAMPLE_W) - fmt.len;
  assign word = sr << pad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else begin
      sr <= sr_nxt;
      if (tr)               cnt <= CNT_W'(1);
      else if (cnt != CMAX) cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lat,
  input  logic                is_left,
  input  logic                clear,
  input  logic [SAMPLE_W-1:0] word,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right
);

  logic [SAMPLE_W-1:0] left_hold;
  logic                have_left;
  logic                slot_free;

  assign slot_free = !smp_valid || smp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      have_left <= 1'b0;
      smp_valid <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
    end else begin
      if (smp_valid && smp_ready) smp_valid <= 1'b0;
      if (clear) begin
        have_left <= 1'b0;
      end else if (lat) begin
        if (is_left) begin
          left_hold <= word;
          have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
          if (have_left && slot_free) begin
            smp_left  <= left_hold;
            smp_right <= word;
            smp_valid <= 1'b1;
          end
        end
      end
    end
  end

  // R10: a stalled pair is held unchanged
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_left) && $stable(smp_right));

  // R9: a pair is only released when a left half was waiting
  a_r9_needs_left: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(have_left));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic                word_clk,
  input  logic                ser_data,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right
);

  logic                tr, lat, chg, lvl_prev, is_left;
  fmt_t                fmt;
  logic [SAMPLE_W-1:0] word;

  aud_rx_frame_sync u_sync (
    .clk      (bit_clk),
    .rst_n    (rst_n),
    .word_clk (word_clk),
    .fmt_sel  (fmt_sel),
    .tr       (tr),
    .lat      (lat),
    .chg      (chg),
    .lvl_prev (lvl_prev),
    .fmt      (fmt)
  );

  aud_rx_deser #(.CNT_W(CNT_W)) u_deser (
    .clk      (bit_clk),
    .rst_n    (rst_n),
    .ser_data (ser_data),
    .tr       (tr),
    .fmt      (fmt),
    .word     (word)
  );

  // I2S framing inverts the channel polarity
  assign is_left = lvl_prev ^ fmt.delay1;

  aud_rx_pair u_pair (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .lat       (lat),
    .is_left   (is_left),
    .clear     (chg),
    .word      (word),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_left  (smp_left),
    .smp_right (smp_right)
  );

  // R9: output appears right after a right-channel close
  a_r9_rise_on_close: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(lat && !is_left));

  // R3: 16-bit right-justified samples carry zero low byte
  a_r3_l16_low_zero: assert property (@(posedge bit_clk) disable iff (!rst_n)
    lat && fmt.rjust && (fmt.len == 5'd16) |-> (word[7:0] == 8'h00));

  // R4: 20-bit right-justified samples carry zero low nibble
  a_r4_l20_low_zero: assert property (@(posedge bit_clk) disable iff (!rst_n)
    lat && fmt.rjust && (fmt.len == 5'd20) |-> (word[3:0] == 4'h0));

endmodule

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;

  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd2;
  logic        word_clk = 1'b1;
  logic        ser_data = 1'b0;
  logic        smp_ready = 1'b1;
  logic        smp_valid;
  logic [23:0] smp_left, smp_right;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [47:0] expq[$];
  string       cur_tag = "R1";
  bit          rdy_rand = 1'b0;
  bit          pend_chk = 1'b0;

  aud_serial_rx u_aud_serial_rx (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .word_clk  (word_clk),
    .ser_data  (ser_data),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_left  (smp_left),
    .smp_right (smp_right)
  );

  always #5 bit_clk = ~bit_clk;

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int eff_code(input int code);
    return (code > 4) ? 2 : code;
  endfunction

  function automatic int samp_len(input int code);
    int e = eff_code(code);
    return (e == 0) ? 16 : (e == 1) ? 20 : 24;
  endfunction

  function automatic logic left_lvl(input int code);
    return (eff_code(code) == 3) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [23:0] rand_sample(input int code);
    logic [23:0] m = 24'hFFFFFF << (24 - samp_len(code));
    return 24'($urandom) & m;
  endfunction

  // one half-frame of H bit clocks; unused positions carry random bits
  task automatic send_half(input logic lvl, input logic [23:0] s, input int code, input int H);
    int e = eff_code(code);
    int n = samp_len(code);
    for (int k = 0; k < H; k++) begin
      @(negedge bit_clk);
      if (k == 1 && pend_chk) begin
        pend_chk = 1'b0;
        chk({cur_tag, " R9 valid after close"}, {47'd0, smp_valid}, 48'd1);
      end
      word_clk = lvl;
      ser_data = 1'($urandom);
      if (e == 2) begin
        if (k < 24) ser_data = s[23-k];
      end else if (e == 3) begin
        if (k >= 1 && k < 25) ser_data = s[24-k];
      end else begin
        if (k >= H - n) ser_data = s[23-(k-(H-n))];
      end
    end
  endtask

  task automatic send_frame(input int code, input logic [23:0] l, input logic [23:0] r,
                            input int H, input bit expect_out);
    if (expect_out) expq.push_back({l, r});
    send_half(left_lvl(code), l, code, H);
    send_half(!left_lvl(code), r, code, H);
    pend_chk = 1'b1;
  endtask

  task automatic start_seg(input int code, input int hmin);
    @(negedge bit_clk);
    rst_n = 1'b0;
    fmt_sel = 3'(code);
    word_clk = left_lvl(code);
    pend_chk = 1'b0;
    repeat (3) @(negedge bit_clk);
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk("R11 valid low after reset", {47'd0, smp_valid}, 48'd0);
    // partial left, then a right half with no left before it
    send_half(left_lvl(code), 24'h0, code, 5);
    send_half(!left_lvl(code), rand_sample(code), code, hmin);
  endtask

  task automatic end_seg(input int code);
    send_half(left_lvl(code), 24'h0, code, 4);
    repeat (12) @(negedge bit_clk);
    chk({cur_tag, " R9 all pairs seen"}, 48'(expq.size()), 48'd0);
    expq.delete();
  endtask

  task automatic run_seg(input string tag, input int code, input int nf,
                         input int hmin, input int hmax);
    cur_tag = tag;
    rdy_rand = 1'b1;
    start_seg(code, hmin);
    for (int f = 0; f < nf; f++) begin
      int h = hmin + int'($urandom % 32'(hmax - hmin + 1));
      send_frame(code, rand_sample(code), rand_sample(code), h, 1'b1);
    end
    end_seg(code);
  endtask

  // downstream ready, mostly high
  always @(negedge bit_clk) if (rdy_rand) smp_ready = ($urandom % 4) != 0;

  // output monitor
  always @(negedge bit_clk) begin
    #2;
    if (rst_n && smp_valid && smp_ready) begin
      if (expq.size() == 0) chk({cur_tag, " R9 unexpected pair"}, {smp_left, smp_right}, 48'hx);
      else chk({cur_tag, " pair"}, {smp_left, smp_right}, expq.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge bit_clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] l1, r1, l3, r3;
    void'($urandom(32'd1234));
    run_seg("R1 R6", 2, 8, 48, 64);
    run_seg("R2", 3, 8, 48, 64);
    run_seg("R3 R6", 0, 8, 32, 32);
    run_seg("R3 R7", 0, 6, 33, 64);
    run_seg("R4", 1, 8, 40, 56);
    run_seg("R5 R6", 4, 8, 48, 64);
    run_seg("R7", 4, 4, 100, 250);
    run_seg("R8", 5, 5, 48, 60);
    run_seg("R8", 7, 5, 48, 60);
    // directed: sign extremes in each channel
    cur_tag = "R1 extremes";
    rdy_rand = 1'b1;
    start_seg(2, 48);
    send_frame(2, 24'h800000, 24'h7FFFFF, 48, 1'b1);
    send_frame(2, 24'hFFFFFF, 24'h000001, 48, 1'b1);
    end_seg(2);
    // directed: back-pressure, second pair dropped
    cur_tag = "R10";
    rdy_rand = 1'b0;
    smp_ready = 1'b0;
    start_seg(2, 48);
    l1 = 24'h123456; r1 = 24'hABCDEF;
    l3 = 24'h0F0F0F; r3 = 24'hF0F0F0;
    send_frame(2, l1, r1, 50, 1'b1);
    send_frame(2, 24'h555555, 24'hAAAAAA, 50, 1'b0);
    expq.push_back({l3, r3});
    send_half(left_lvl(2), l3, 2, 50);
    chk("R10 held pair", {smp_valid, smp_left, smp_right}, {1'b1, l1, r1});
    @(negedge bit_clk);
    smp_ready = 1'b1;
    send_half(!left_lvl(2), r3, 2, 50);
    pend_chk = 1'b1;
    end_seg(2);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule